// File: doc/BRIEF.md
# Pin Pull-Resistor Control Bank

This block holds the pull-up and pull-down selections for the pins of two 16-pin I/O ports and sits on an APB slave interface. There are four 16-bit control words: a pull-up word and a pull-down word for each port. A global apply input gates all of them. When apply is high, each pin's stored selection drives a pull-up enable or a pull-down enable output. If both of a pin's bits are set, pull-down wins.

Every register access is stretched by a fixed number of wait states: 3 for a write and 2 for a read. The stored words belong to a retention domain. Only the dedicated retention reset clears them. The standby-exit reset only returns the bus interface to idle.

On the second port, a parameter mask marks some pins as not implemented. Those bits read as zero and ignore writes.

Top module: `pull_ctrl_apb`

## Requirements
- R1: The byte offsets map as follows: 0x30 is the first-port pull-up word, 0x34 is the first-port pull-down word, 0x38 is the second-port pull-up word and 0x3C is the second-port pull-down word. Bit n of a word belongs to pin n, for n from 0 to 15. A write followed by a read of the same offset returns the written pin bits.
- R2: The retention reset clears all four words to 0x0000_0000, and with them every pull enable output.
- R3: The pull-up enable of a pin is 1 exactly when its pull-up bit is 1, its pull-down bit is 0 and the apply input is 1.
- R4: The pull-down enable of a pin is 1 exactly when its pull-down bit is 1 and apply is 1, whatever its pull-up bit holds.
- R5: PREADY stays low for exactly 3 access-phase cycles of a write and exactly 2 of a read, then rises in the next access-phase cycle.
- R6: Write data bits 31:16 are discarded, and PRDATA bits 31:16 always read as 0.
- R7: With the default mask 0xE0C0, second-port pins 0 to 5 and 8 to 12 read as 0 and ignore writes, in both the pull-up word and the pull-down word.
- R8: An address that is not one of the four word offsets counts as unmapped. An unmapped access reads 0, raises PSLVERR in the PREADY cycle and changes no register. PSLVERR stays low for mapped accesses.
- R9: Asserting the standby-exit reset leaves all four words and all pull enable outputs unchanged.
- R10: A write changes the stored word and the enable outputs only at the clock edge that ends the PREADY-high access cycle. During the wait cycles the outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and register clock |
| sys_rst_n | input | 1 | Standby-exit reset, active low; resets only the bus wait logic |
| ret_rst_n | input | 1 | Retention-domain reset, active low; clears the control words |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid with PREADY |
| pready | output | 1 | APB ready; low during wait states |
| pslverr | output | 1 | APB error for unmapped offsets |
| apply_en | input | 1 | Global apply enable for all pull devices |
| pu_en_c | output | 16 | Pull-up enables, first port |
| pd_en_c | output | 16 | Pull-down enables, first port |
| pu_en_d | output | 16 | Pull-up enables, second port |
| pd_en_d | output | 16 | Pull-down enables, second port |

## Verification
Two things can land in the same cycle. One is a register write that completes, as PREADY rises with PENABLE. The other is a change on the apply input, and both shape the same enable outputs. The bench drops apply exactly in the PREADY cycle of a write to a pull-down word. It then checks that the outputs are all zero on the next cycle. When apply comes back, it checks that the outputs show the newly written word, with pull-down priority applied to each pin.

// File: rtl/pull_pkg.sv
package pull_pkg;

    localparam int NUM_PORTS = 2;
    localparam int NUM_KINDS = 2;
    localparam int NUM_REGS  = NUM_PORTS * NUM_KINDS;
    localparam int IDX_W     = $clog2(NUM_REGS);

    typedef enum logic {
        KIND_UP   = 1'b0,
        KIND_DOWN = 1'b1
    } pull_kind_e;

    function automatic int reg_index(input int port, input pull_kind_e kind);
        return port * NUM_KINDS + int'(kind);
    endfunction

endpackage

// File: rtl/pull_decode.sv
module pull_decode #(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] BASE_OFF = 12'h030
) (
    input  logic [ADDR_W-1:0]        paddr,
    output logic                     hit,
    output logic [pull_pkg::IDX_W-1:0] idx
);
    localparam int LOW_W = pull_pkg::IDX_W + 2;

    always_comb begin
        hit = (paddr[ADDR_W-1:LOW_W] == BASE_OFF[ADDR_W-1:LOW_W]) && (paddr[1:0] == 2'b00);
        idx = paddr[LOW_W-1:2];
    end

endmodule

// File: rtl/pull_wait.sv
module pull_wait #(
    parameter int WR_EXTRA = 3,
    parameter int RD_EXTRA = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic pready
);
    localparam int MAX_EXTRA = (WR_EXTRA > RD_EXTRA) ? WR_EXTRA : RD_EXTRA;
    localparam int CNT_W     = $clog2(MAX_EXTRA + 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wait_st_t;

    wait_st_t st_d, st_q;
    logic     in_access;
    logic [CNT_W-1:0] need;

    always_comb begin
        in_access = psel && penable;
        need      = pwrite ? CNT_W'(WR_EXTRA) : CNT_W'(RD_EXTRA);
        pready    = in_access && (st_q.cnt == need);
        st_d      = st_q;
        if (in_access && !pready) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r5_ready_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        pready |-> (psel && penable));

    generate
        if (WR_EXTRA > 0 && RD_EXTRA > 0) begin : g_first_wait
            a_r5_first_access_waits: assert property (@(posedge clk) disable iff (!rst_n)
                (psel && $rose(penable)) |-> !pready);
        end
    endgenerate

endmodule

// File: rtl/pull_regbank.sv
module pull_regbank #(
    parameter int              PIN_W  = 16,
    parameter logic [PIN_W-1:0] MASK_C = 16'hFFFF,
    parameter logic [PIN_W-1:0] MASK_D = 16'hE0C0
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [pull_pkg::IDX_W-1:0]             wr_idx,
    input  logic [PIN_W-1:0]                       wr_data,
    output logic [pull_pkg::NUM_REGS-1:0][PIN_W-1:0] regs
);
    import pull_pkg::*;

    typedef struct packed {
        logic [NUM_REGS-1:0][PIN_W-1:0] word;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [NUM_REGS-1:0][PIN_W-1:0] mask;

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_mask
            assign mask[r] = ((r / NUM_KINDS) == 0) ? MASK_C : MASK_D;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (wr_en && (wr_idx == IDX_W'(r))) begin
                st_d.word[r] = wr_data & mask[r];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs = st_q.word;

    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
            a_r7_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (regs[r] & ~mask[r]) == '0);
        end
    endgenerate

endmodule

// File: rtl/pull_drive.sv
module pull_drive #(
    parameter int PIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply,
    input  logic [PIN_W-1:0] up_sel,
    input  logic [PIN_W-1:0] down_sel,
    output logic [PIN_W-1:0] up_en,
    output logic [PIN_W-1:0] down_en
);
    generate
        for (genvar i = 0; i < PIN_W; i++) begin : g_pin
            assign down_en[i] = apply & down_sel[i];
            assign up_en[i]   = apply & up_sel[i] & ~down_sel[i];
        end
    endgenerate

    a_r4_down_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en & down_en) == '0);

    a_r3_apply_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |-> (up_en == '0 && down_en == '0));

endmodule

// File: rtl/pull_ctrl_apb.sv
module pull_ctrl_apb #(
    parameter int                ADDR_W   = 12,
    parameter int                DATA_W   = 32,
    parameter int                PIN_W    = 16,
    parameter int                WR_EXTRA = 3,
    parameter int                RD_EXTRA = 2,
    parameter logic [ADDR_W-1:0] BASE_OFF = 12'h030,
    parameter logic [PIN_W-1:0]  MASK_C   = 16'hFFFF,
    parameter logic [PIN_W-1:0]  MASK_D   = 16'hE0C0
) (
    input  logic              pclk,
    input  logic              sys_rst_n,
    input  logic              ret_rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              apply_en,
    output logic [PIN_W-1:0]  pu_en_c,
    output logic [PIN_W-1:0]  pd_en_c,
    output logic [PIN_W-1:0]  pu_en_d,
    output logic [PIN_W-1:0]  pd_en_d
);
    import pull_pkg::*;

    logic                           hit;
    logic [IDX_W-1:0]               idx;
    logic                           wr_en;
    logic [NUM_REGS-1:0][PIN_W-1:0] regs;
    logic [NUM_PORTS-1:0][PIN_W-1:0] up_all, down_all;
    logic                           unused_hi;

    assign unused_hi = ^pwdata[DATA_W-1:PIN_W];

    pull_decode #(.ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)) u_dec (
        .paddr (paddr),
        .hit   (hit),
        .idx   (idx)
    );

    pull_wait #(.WR_EXTRA(WR_EXTRA), .RD_EXTRA(RD_EXTRA)) u_wait (
        .clk     (pclk),
        .rst_n   (sys_rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .pready  (pready)
    );

    always_comb begin
        wr_en   = pready && pwrite && hit;
        pslverr = pready && !hit;
        prdata  = '0;
        if (pready && !pwrite && hit) begin
            prdata[PIN_W-1:0] = regs[idx];
        end
    end

    pull_regbank #(.PIN_W(PIN_W), .MASK_C(MASK_C), .MASK_D(MASK_D)) u_bank (
        .clk     (pclk),
        .rst_n   (ret_rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (pwdata[PIN_W-1:0]),
        .regs    (regs)
    );

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            pull_drive #(.PIN_W(PIN_W)) u_drv (
                .clk      (pclk),
                .rst_n    (ret_rst_n),
                .apply    (apply_en),
                .up_sel   (regs[reg_index(p, KIND_UP)]),
                .down_sel (regs[reg_index(p, KIND_DOWN)]),
                .up_en    (up_all[p]),
                .down_en  (down_all[p])
            );
        end
    endgenerate

    assign pu_en_c = up_all[0];
    assign pd_en_c = down_all[0];
    assign pu_en_d = up_all[1];
    assign pd_en_d = down_all[1];

    a_r8_err_with_ready: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        pslverr |-> pready);

    a_r6_upper_read_zero: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        pready |-> (prdata[DATA_W-1:PIN_W] == '0));

    a_r8_err_read_zero: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        pslverr |-> (prdata == '0));

endmodule

// File: tb/pull_ctrl_apb_test.sv
`timescale 1ns/1ps
module pull_ctrl_apb_test;
    logic        pclk = 1'b0;
    logic        sys_rst_n = 1'b0, ret_rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        apply_en = 1'b0;
    logic [15:0] pu_en_c, pd_en_c, pu_en_d, pd_en_d;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 pclk = ~pclk;

    pull_ctrl_apb uut (
        .pclk(pclk), .sys_rst_n(sys_rst_n), .ret_rst_n(ret_rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .apply_en(apply_en), .pu_en_c(pu_en_c), .pd_en_c(pd_en_c),
        .pu_en_d(pu_en_d), .pd_en_d(pd_en_d)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [11:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int waits, output logic err);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = wd;
        @(negedge pclk);
        penable = 1'b1;
        waits = 0;
        #0.5;
        while (!pready && waits < 20) begin
            @(negedge pclk); #0.5;
            waits++;
        end
        rd = prdata; err = pslverr;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr_reg(input logic [11:0] addr, input logic [31:0] wd);
        logic [31:0] rd; int w; logic e;
        xfer(1'b1, addr, wd, rd, w, e);
    endtask

    task automatic rd_reg(input logic [11:0] addr, output logic [31:0] rd);
        int w; logic e;
        xfer(1'b0, addr, '0, rd, w, e);
    endtask

    task automatic t_reset();
        logic [31:0] rd;
        for (int i = 0; i < 4; i++) begin
            rd_reg(12'h030 + 12'(4 * i), rd);
            chk("R2 reset word", rd, 32'h0);
        end
        apply_en = 1'b1; #0.5;
        chk("R2 reset outputs", {pu_en_c, pd_en_c}, 32'h0);
        chk("R2 reset outputs d", {pu_en_d, pd_en_d}, 32'h0);
        apply_en = 1'b0;
    endtask

    task automatic t_wait();
        logic [31:0] rd; int w; logic e;
        xfer(1'b1, 12'h030, 32'h0000_00FF, rd, w, e);
        chk("R5 write waits", 32'(w), 32'd3);
        chk("R8 mapped write no error", {31'b0, e}, 32'h0);
        xfer(1'b0, 12'h030, '0, rd, w, e);
        chk("R5 read waits", 32'(w), 32'd2);
        chk("R1 readback 0x30", rd, 32'h0000_00FF);
        chk("R8 mapped read no error", {31'b0, e}, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] rd;
        wr_reg(12'h034, 32'hABCD_1234);
        rd_reg(12'h034, rd);
        chk("R6 upper bits dropped", rd, 32'h0000_1234);
    endtask

    task automatic t_mask();
        logic [31:0] rd;
        wr_reg(12'h038, 32'hFFFF_FFFF);
        rd_reg(12'h038, rd);
        chk("R7 second-port pull-up mask", rd, 32'h0000_E0C0);
        wr_reg(12'h03C, 32'h0000_1F3F);
        rd_reg(12'h03C, rd);
        chk("R7 second-port pull-down mask", rd, 32'h0);
        wr_reg(12'h03C, 32'h0000_4080);
        rd_reg(12'h03C, rd);
        chk("R1 readback 0x3C", rd, 32'h0000_4080);
    endtask

    task automatic t_logic();
        wr_reg(12'h030, 32'h0000_00FF);
        wr_reg(12'h034, 32'h0000_0F0F);
        apply_en = 1'b1; #0.5;
        chk("R3 pull-up first port", {16'h0, pu_en_c}, 32'h0000_00F0);
        chk("R4 pull-down first port", {16'h0, pd_en_c}, 32'h0000_0F0F);
        chk("R3 pull-up second port", {16'h0, pu_en_d}, 32'h0000_A040);
        chk("R4 pull-down second port", {16'h0, pd_en_d}, 32'h0000_4080);
        apply_en = 1'b0; #0.5;
        chk("R3 apply low", {pu_en_c, pu_en_d}, 32'h0);
        chk("R4 apply low", {pd_en_c, pd_en_d}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] rd; int w; logic e;
        xfer(1'b0, 12'h040, '0, rd, w, e);
        chk("R8 unmapped read data", rd, 32'h0);
        chk("R8 unmapped read error", {31'b0, e}, 32'h1);
        xfer(1'b1, 12'h031, 32'h0000_FFFF, rd, w, e);
        chk("R8 misaligned write error", {31'b0, e}, 32'h1);
        xfer(1'b1, 12'h02C, 32'h0000_FFFF, rd, w, e);
        chk("R8 unmapped write error", {31'b0, e}, 32'h1);
        rd_reg(12'h030, rd);
        chk("R8 0x30 unchanged", rd, 32'h0000_00FF);
        rd_reg(12'h034, rd);
        chk("R8 0x34 unchanged", rd, 32'h0000_0F0F);
    endtask

    task automatic t_commit();
        apply_en = 1'b1;
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h034; pwdata = 32'h0000_0000;
        @(negedge pclk);
        penable = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #0.5;
            chk("R10 wait cycle pready", {31'b0, pready}, 32'h0);
            chk("R10 outputs held", {16'h0, pd_en_c}, 32'h0000_0F0F);
            @(negedge pclk);
        end
        #0.5;
        chk("R10 ready cycle", {31'b0, pready}, 32'h1);
        chk("R10 held in ready cycle", {16'h0, pd_en_c}, 32'h0000_0F0F);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #0.5;
        chk("R10 pull-down after commit", {16'h0, pd_en_c}, 32'h0);
        chk("R10 pull-up after commit", {16'h0, pu_en_c}, 32'h0000_00FF);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; paddr = 12'h034; pwdata = 32'h0000_00F0;
        @(negedge pclk);
        penable = 1'b1;
        #0.5;
        while (!pready) begin @(negedge pclk); #0.5; end
        apply_en = 1'b0;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #0.5;
        chk("R3 apply dropped at commit", {pu_en_c, pd_en_c}, 32'h0);
        apply_en = 1'b1; #0.5;
        chk("R4 new pull-down", {16'h0, pd_en_c}, 32'h0000_00F0);
        chk("R3 new pull-up", {16'h0, pu_en_c}, 32'h0000_000F);
    endtask

    task automatic t_standby();
        logic [31:0] rd;
        @(negedge pclk); sys_rst_n = 1'b0;
        repeat (3) @(negedge pclk);
        #0.5;
        chk("R9 outputs during standby reset", {pu_en_c, pd_en_c}, 32'h000F_00F0);
        sys_rst_n = 1'b1;
        @(negedge pclk); #0.5;
        chk("R9 second port kept", {pu_en_d, pd_en_d}, 32'hA040_4080);
        rd_reg(12'h034, rd);
        chk("R9 word kept", rd, 32'h0000_00F0);
    endtask

    task automatic t_retention();
        logic [31:0] rd;
        @(negedge pclk); ret_rst_n = 1'b0;
        @(negedge pclk); ret_rst_n = 1'b1;
        #0.5;
        chk("R2 outputs cleared", {pu_en_c, pd_en_c}, 32'h0);
        rd_reg(12'h038, rd);
        chk("R2 word cleared", rd, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge pclk);
        sys_rst_n = 1'b1; ret_rst_n = 1'b1;
        t_reset();
        t_wait();
        t_reserved();
        t_mask();
        t_logic();
        t_unmapped();
        t_commit();
        t_standby();
        t_retention();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule